// File: doc/BRIEF.md
# Ternary Two-Wire Gate Property Classifier

This block inspects a two-input, two-output gate over the values {0,1,2}. It receives the gate's whole truth table as two output columns, P and Q. It reports whether the gate is a permutation of its nine input pairs and whether each output column is balanced. It also reports whether the gate can copy one input onto both outputs by tying the other input to a constant. When no exact copy exists, it reports whether the gate can at least reach every value on both outputs under such a tie-off.

A caller presents both columns with a valid strobe. One clock later the block returns flags, plus the fixed input and constant that witness each copying property. The result is held until the next strobe. Row `r` of a column is the gate's output for inputs `A = r / 3` and `B = r % 3`, so `r = 3*A + B`.

Top module: `tgc_classifier`

## Requirements
- R1: Row r of each column sits at bits [2r+1:2r] of its input port. The codes 00, 01 and 10 mean 0, 1 and 2. If any of the eighteen trits holds 11, `code_err` is set and every other result flag and witness field is 0.
- R2: Results load on the rising edge at which `in_valid` is high, and `out_valid` is high for the one cycle after that edge. While `in_valid` is low, `out_valid` goes low and all result outputs keep their values.
- R3: A synchronous active-high `rst` clears `out_valid` and every result output.
- R4: `rev_ok` is 1 exactly when the nine (P,Q) pairs are pairwise distinct.
- R5: `bal_p` (`bal_q`) is 1 exactly when each of 0, 1 and 2 appears three times in column P (Q).
- R6: `dup_ok` is 1 when fixing one input to a constant makes both P and Q, read as functions of the free input, equal to the identity 0,1,2. `dup_on_b` (0 = A fixed, 1 = B fixed) and `dup_const` name the witness.
- R7: The six candidates are tried in the order A=0, A=1, A=2, B=0, B=1, B=2, and the first one that matches is reported.
- R8: `qdup_ok` is 1 when `dup_ok` is 0 and some candidate makes both restricted functions permutations of {0,1,2}. Its witness is `qdup_on_b` and `qdup_const`, chosen with the priority of R7.
- R9: `dup_ok` and `qdup_ok` are never 1 together.
- R10: When a property flag is 0, its witness side and constant outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Columns are presented this cycle |
| col_p | input | 18 | Output column P, row r at bits [2r+1:2r] |
| col_q | input | 18 | Output column Q, same packing |
| out_valid | output | 1 | Result loaded on the last edge |
| code_err | output | 1 | Some trit held the illegal code |
| rev_ok | output | 1 | Gate is a permutation of its input pairs |
| bal_p | output | 1 | Column P is balanced |
| bal_q | output | 1 | Column Q is balanced |
| dup_ok | output | 1 | Copying property holds |
| dup_on_b | output | 1 | Copy witness fixes B (0 means A) |
| dup_const | output | 2 | Constant of the copy witness |
| qdup_ok | output | 1 | Weak copying property holds |
| qdup_on_b | output | 1 | Weak copy witness fixes B (0 means A) |
| qdup_const | output | 2 | Constant of the weak copy witness |

## Verification
The properties assume that `rst` is applied at start-up and that every column handed in may be any 18-bit value, illegal codes included. Beyond that they assume only that `in_valid` is a plain level. The stimulus keeps this promise: it drives columns and strobe only on falling edges and holds reset for several cycles before the first strobe. It deliberately includes columns that are legal but not permutations, and columns with an illegal code in either P or Q. This exercises the invariants linking the balance, permutation and copy flags across the whole input space, not just over reversible gates.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TRIT_W = 2;
    localparam int RADIX  = 3;
    localparam int ROWS   = RADIX * RADIX;
    localparam int COL_W  = ROWS * TRIT_W;
    localparam int NCAND  = 2 * RADIX;
    localparam int CNT_W  = $clog2(ROWS + 1);

    typedef logic [TRIT_W-1:0]            trit_t;
    typedef logic [ROWS-1:0][TRIT_W-1:0]  col_t;
    typedef logic [RADIX-1:0][TRIT_W-1:0] rfun_t;

    typedef struct packed {
        logic  hit;
        logic  on_b;
        trit_t cval;
    } witness_t;

    typedef struct packed {
        logic     err;
        logic     rev;
        logic     bal_p;
        logic     bal_q;
        witness_t dup;
        witness_t qdup;
    } result_t;

    function automatic logic trit_ok(trit_t t);
        return int'(t) < RADIX;
    endfunction

    function automatic logic is_ident(rfun_t f);
        logic ok;
        ok = 1'b1;
        for (int x = 0; x < RADIX; x++)
            if (f[x] != trit_t'(x)) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic is_perm(rfun_t f);
        logic ok;
        ok = 1'b1;
        for (int x = 0; x < RADIX; x++) begin
            if (!trit_ok(f[x])) ok = 1'b0;
            for (int y = x + 1; y < RADIX; y++)
                if (f[x] == f[y]) ok = 1'b0;
        end
        return ok;
    endfunction

    // lowest candidate index wins: A=0..2 then B=0..2
    function automatic witness_t pick_first(logic [NCAND-1:0] hits);
        witness_t w;
        w = '0;
        for (int k = NCAND - 1; k >= 0; k--) begin
            if (hits[k]) begin
                w.hit  = 1'b1;
                w.on_b = (k >= RADIX);
                w.cval = trit_t'(k % RADIX);
            end
        end
        return w;
    endfunction
endpackage

// File: rtl/tgc_colstat.sv
module tgc_colstat
    import tgc_pkg::*;
(
    input  col_t col,
    output logic legal,
    output logic balanced
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PER_VAL = ROWS / RADIX;

    logic [CNT_W-1:0] cnt [RADIX];

    always_comb begin
        legal = 1'b1;
        for (int r = 0; r < ROWS; r++)
            if (!trit_ok(col[r])) legal = 1'b0;
    end

    always_comb begin
        balanced = 1'b1;
        for (int v = 0; v < RADIX; v++) begin
            cnt[v] = '0;
            for (int r = 0; r < ROWS; r++)
                if (col[r] == trit_t'(v)) cnt[v] = cnt[v] + 1'b1;
            if (cnt[v] != CNT_W'(PER_VAL)) balanced = 1'b0;
        end
    end
endmodule

// File: rtl/tgc_distinct.sv
module tgc_distinct
    import tgc_pkg::*;
(
    input  col_t col_p,
    input  col_t col_q,
    output logic all_distinct
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        all_distinct = 1'b1;
        for (int i = 0; i < ROWS; i++)
            for (int j = i + 1; j < ROWS; j++)
                if ({col_p[i], col_q[i]} == {col_p[j], col_q[j]})
                    all_distinct = 1'b0;
    end
endmodule

// File: rtl/tgc_cand.sv
module tgc_cand
    import tgc_pkg::*;
#(
    parameter bit ON_B = 1'b0,
    parameter int CVAL = 0
) (
    input  col_t col_p,
    input  col_t col_q,
    output logic ident,
    output logic perm
);
    timeunit 1ns;
    timeprecision 1ps;

    rfun_t fp;
    rfun_t fq;

    always_comb begin
        for (int x = 0; x < RADIX; x++) begin
            fp[x] = col_p[ON_B ? (x * RADIX + CVAL) : (CVAL * RADIX + x)];
            fq[x] = col_q[ON_B ? (x * RADIX + CVAL) : (CVAL * RADIX + x)];
        end
    end

    assign ident = is_ident(fp) && is_ident(fq);
    assign perm  = is_perm(fp) && is_perm(fq);
endmodule

// File: rtl/tgc_classifier.sv
module tgc_classifier
    import tgc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [COL_W-1:0] col_p,
    input  logic [COL_W-1:0] col_q,
    output logic             out_valid,
    output logic             code_err,
    output logic             rev_ok,
    output logic             bal_p,
    output logic             bal_q,
    output logic             dup_ok,
    output logic             dup_on_b,
    output logic [TRIT_W-1:0] dup_const,
    output logic             qdup_ok,
    output logic             qdup_on_b,
    output logic [TRIT_W-1:0] qdup_const
);
    timeunit 1ns;
    timeprecision 1ps;

    col_t cp;
    col_t cq;
    assign cp = col_p;
    assign cq = col_q;

    logic legal_p, legal_q, bp, bq, distinct;
    logic [NCAND-1:0] ident_hits;
    logic [NCAND-1:0] perm_hits;

    tgc_colstat u_stat_p (.col(cp), .legal(legal_p), .balanced(bp));
    tgc_colstat u_stat_q (.col(cq), .legal(legal_q), .balanced(bq));
    tgc_distinct u_dist (.col_p(cp), .col_q(cq), .all_distinct(distinct));

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        tgc_cand #(
            .ON_B(k >= RADIX),
            .CVAL(k % RADIX)
        ) u_cand (
            .col_p(cp),
            .col_q(cq),
            .ident(ident_hits[k]),
            .perm (perm_hits[k])
        );
    end

    result_t res_d;
    result_t res_q;
    logic    vld_q;

    always_comb begin
        res_d = '0;
        if (!(legal_p && legal_q)) begin
            res_d.err = 1'b1;
        end else begin
            res_d.rev   = distinct;
            res_d.bal_p = bp;
            res_d.bal_q = bq;
            res_d.dup   = pick_first(ident_hits);
            if (!res_d.dup.hit)
                res_d.qdup = pick_first(perm_hits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_valid  = vld_q;
    assign code_err   = res_q.err;
    assign rev_ok     = res_q.rev;
    assign bal_p      = res_q.bal_p;
    assign bal_q      = res_q.bal_q;
    assign dup_ok     = res_q.dup.hit;
    assign dup_on_b   = res_q.dup.on_b;
    assign dup_const  = res_q.dup.cval;
    assign qdup_ok    = res_q.qdup.hit;
    assign qdup_on_b  = res_q.qdup.on_b;
    assign qdup_const = res_q.qdup.cval;
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker
    import tgc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic              code_err,
    input logic              rev_ok,
    input logic              bal_p,
    input logic              bal_q,
    input logic              dup_ok,
    input logic              dup_on_b,
    input logic [TRIT_W-1:0] dup_const,
    input logic              qdup_ok,
    input logic              qdup_on_b,
    input logic [TRIT_W-1:0] qdup_const
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_reset_clears_R3: assert property (@(posedge clk)
        rst |=> !out_valid && !code_err && !rev_ok && !dup_ok && !qdup_ok);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(rev_ok) && $stable(dup_ok) && $stable(qdup_ok)
                      && $stable(code_err) && $stable(dup_const));

    assert_err_clears_R1: assert property (@(posedge clk) disable iff (rst)
        code_err |-> !rev_ok && !bal_p && !bal_q && !dup_ok && !qdup_ok);

    // R4 with R5: a permutation gate always has balanced columns
    assert_rev_balanced_R4: assert property (@(posedge clk) disable iff (rst)
        rev_ok |-> bal_p && bal_q);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(dup_ok && qdup_ok));

    assert_dup_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !dup_ok |-> !dup_on_b && dup_const == '0);

    assert_qdup_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !qdup_ok |-> !qdup_on_b && qdup_const == '0);

    assert_const_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(dup_const) < RADIX && int'(qdup_const) < RADIX);
endmodule

bind tgc_classifier tgc_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .code_err(code_err), .rev_ok(rev_ok), .bal_p(bal_p), .bal_q(bal_q),
    .dup_ok(dup_ok), .dup_on_b(dup_on_b), .dup_const(dup_const),
    .qdup_ok(qdup_ok), .qdup_on_b(qdup_on_b), .qdup_const(qdup_const)
);

// File: tb/sim_tgc_classifier.sv
module sim_tgc_classifier;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NV = 10;
    // columns written as nine digits, row 0 first; digit 3 marks the illegal code
    localparam int VP [NV] = '{012010212, 000112212, 000111222, 012012012, 000001002,
                               012012012, 000012020, 120120120, 012010213, 012010212};
    localparam int VQ [NV] = '{012122100, 201010122, 012012012, 000111222, 000001002,
                               012012012, 000012020, 120120120, 012122100, 312122100};
    // expected digits: err rev bal_p bal_q dup dside dconst qdup qside qconst
    localparam int VE [NV] = '{0111100000, 0111000110, 0111000000, 0111000000, 0000112000,
                               0011100000, 0000101000, 0011000100, 1000000000, 1000000000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [17:0] col_p = '0;
    logic [17:0] col_q = '0;
    logic out_valid, code_err, rev_ok, bal_p, bal_q;
    logic dup_ok, dup_on_b, qdup_ok, qdup_on_b;
    logic [1:0] dup_const, qdup_const;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tgc_classifier u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .col_p(col_p), .col_q(col_q),
        .out_valid(out_valid), .code_err(code_err), .rev_ok(rev_ok),
        .bal_p(bal_p), .bal_q(bal_q), .dup_ok(dup_ok), .dup_on_b(dup_on_b),
        .dup_const(dup_const), .qdup_ok(qdup_ok), .qdup_on_b(qdup_on_b),
        .qdup_const(qdup_const)
    );

    function automatic logic [17:0] pack(int n);
        logic [17:0] c;
        for (int r = 8; r >= 0; r--) begin
            int d;
            d = n % 10;
            n = n / 10;
            c[2*r +: 2] = (d == 3) ? 2'b11 : 2'(d);
        end
        return c;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic present(int p, int q);
        @(negedge clk);
        col_p = pack(p);
        col_q = pack(q);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 reset state
        check("R3 reset flags",
              int'({out_valid, code_err, rev_ok, bal_p, bal_q, dup_ok, qdup_ok}), 0);

        for (int v = 0; v < NV; v++) begin
            int e;
            int ed [10];
            e = VE[v];
            for (int i = 9; i >= 0; i--) begin
                ed[i] = e % 10;
                e = e / 10;
            end
            present(VP[v], VQ[v]);
            check("R2 out_valid", int'(out_valid), 1);
            check("R1 code_err", int'(code_err), ed[0]);
            check("R4 rev_ok", int'(rev_ok), ed[1]);
            check("R5 bal_p", int'(bal_p), ed[2]);
            check("R5 bal_q", int'(bal_q), ed[3]);
            check("R6 dup_ok", int'(dup_ok), ed[4]);
            check("R7 R10 dup witness", int'(dup_on_b) * 10 + int'(dup_const), ed[5] * 10 + ed[6]);
            check("R8 qdup_ok", int'(qdup_ok), ed[7]);
            check("R8 R10 qdup witness", int'(qdup_on_b) * 10 + int'(qdup_const), ed[8] * 10 + ed[9]);
            check("R9 exclusive", int'(dup_ok && qdup_ok), 0);
        end

        // R2 hold: load a copying gate, then change columns without strobe
        present(VP[0], VQ[0]);
        @(negedge clk);
        col_p = pack(VP[8]);
        col_q = pack(VQ[2]);
        repeat (2) @(negedge clk);
        check("R2 out_valid low", int'(out_valid), 0);
        check("R2 hold dup_ok", int'(dup_ok), 1);
        check("R2 hold code_err", int'(code_err), 0);

        // R3 reset after a loaded result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R3 reset clears", int'({out_valid, rev_ok, bal_p, bal_q, dup_ok}), 0);

        // R1 illegal code in the strobe cycle after a good gate
        present(VP[1], VQ[1]);
        check("R8 qdup before error", int'(qdup_ok), 1);
        present(VP[1], 333333333);
        check("R1 all illegal Q", int'({code_err, qdup_ok, rev_ok}), 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule